// File: doc/BRIEF.md
# Buck Regulator Start-Up and Protection Supervisor

This block is the digital supervisor of a buck regulator controller that also runs two auxiliary linear regulators. Comparators outside the block reduce the analog world to single-bit flags: supply above the reset level, supply above the start level, enable, VID-code-valid, switcher overvoltage at two levels, switcher output within its window, and one below-threshold flag per linear output. The block decides when the switcher may ramp, how long the ramp lasts, and which drivers are on.

Soft start begins only when enable, VID-valid and the start-level flag all hold at once. A counter clocked by the switching clock then times a fixed number of cycles, during which the error amplifier clamp rises gradually; at the end the clamp is released to the loop. Power-good (an open-drain pull-down, 1 = pulled low) is forced active for the whole ramp and afterwards follows the monitors. Undervoltage on a linear output and two tiers of switcher overvoltage are latched until enable is withdrawn or power-on reset occurs, after which a fresh soft start is needed.

Top module: `buck_seq_supervisor`

## Requirements
- R1: While `rst_n` is low or `por_ok` is low, every internal register is cleared asynchronously: `hs_en`, `ls_en`, `ramp_en`, `clamp_release`, `crowbar`, `ldo_a_gate` and `ldo_b_gate` are 0 and `pg_pulldown` is 1. After both are high, the internal reset is released on the second clock edge and the block acts from the third.
- R2: Every level flag passes a two-flop synchronizer. Soft start (`ramp_en` = 1) begins only when `enable`, `vid_ok` and `start_lvl_ok` are high together; `ramp_en` rises after the third clock edge following the cycle in which all three became high.
- R3: The ramp lasts exactly SS_CYCLES (default 4096) clock cycles with no start condition lost; then `ramp_en` falls and `clamp_release` rises in the same cycle and stays high while running.
- R4: If any of the three start conditions (as synchronized) drops during the ramp, the block returns to idle with the count cleared; a later start times a full SS_CYCLES again.
- R5: `pg_pulldown` is 1 whenever the block is not in the released (running) state, including the whole ramp. In the running state it is 1 if the synchronized `sw_pg_ok` is 0 or any undervoltage or overvoltage latch is set, otherwise 0.
- R6: A synchronized low `enable` returns the block to idle: `hs_en`, `ls_en`, `ldo_a_gate`, `ldo_b_gate`, `ramp_en`, `clamp_release` all 0; this is visible after the third clock edge after `enable` falls. Once running, only `enable` (not `vid_ok` or `start_lvl_ok`) ends the run.
- R7: In the running state a synchronized high `ldo_a_low` (or `ldo_b_low`) latches that regulator's gate enable off and drives `pg_pulldown` to 1; the gate stays off after the flag clears.
- R8: A synchronized high `ovp_lvl1` while ramping or running latches `hs_en` to 0 while `ls_en` stays 1.
- R9: A synchronized high `ovp_lvl2` while ramping or running latches `crowbar` to 1 and `hs_en` to 0.
- R10: All protection latches clear only on reset (R1) or a synchronized low `enable`; protected drivers return only after a new full soft start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply above reset level; low holds the block in reset |
| start_lvl_ok | input | 1 | Supply above start level |
| enable | input | 1 | Controller enable; low shuts down |
| vid_ok | input | 1 | VID code valid |
| ovp_lvl1 | input | 1 | Switcher overvoltage, first tier |
| ovp_lvl2 | input | 1 | Switcher overvoltage, second tier |
| ldo_a_low | input | 1 | Linear output A below threshold |
| ldo_b_low | input | 1 | Linear output B below threshold |
| sw_pg_ok | input | 1 | Switcher output within window |
| ramp_en | output | 1 | Soft-start ramp active (clamp rising) |
| clamp_release | output | 1 | Error amplifier released to loop |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |
| crowbar | output | 1 | Crowbar trigger |
| ldo_a_gate | output | 1 | Linear regulator A gate enable |
| ldo_b_gate | output | 1 | Linear regulator B gate enable |
| pg_pulldown | output | 1 | Power-good pull-down enable (1 = low) |

## Verification
A wrong ramp counter shows at once as `clamp_release` rising early or late against a count of 4096, so an off-by-one is caught in the cycle the ramp ends. A latch that clears or sets wrongly appears within one cycle on `hs_en`, `crowbar` or a gate enable, and a lost phase appears on `pg_pulldown` and the driver enables in the cycle it happens. Because every output is compared with an independent model on each clock, a synchronizer stage added or lost is seen as a one-cycle skew on the first edge after any input change.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RAMP = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;

  localparam int IX_EN    = 0;
  localparam int IX_VID   = 1;
  localparam int IX_VST   = 2;
  localparam int IX_OV1   = 3;
  localparam int IX_OV2   = 4;
  localparam int IX_UVA   = 5;
  localparam int IX_UVB   = 6;
  localparam int IX_SWOK  = 7;
  localparam int N_FLAGS  = 8;
endpackage

// File: rtl/sup_reset_sync.sv
module sup_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  output logic rst_q_n
);
  logic             arst_n;
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign arst_n = rst_n & por_ok;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/sup_flag_sync.sv
module sup_flag_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= {st_q[STAGES-2:0], d[i]};
    end
    assign q[i] = st_q[STAGES-1];
  end
endmodule

// File: rtl/sup_ss_timer.sv
module sup_ss_timer
  import sup_pkg::*;
#(
  parameter int SS_CYCLES = 4096
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_ok,
  input  logic   en_s,
  output phase_t phase
);
  localparam int CW = (SS_CYCLES > 1) ? $clog2(SS_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SS_CYCLES - 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_we;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_we = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_ok) begin
          ph_d   = PH_RAMP;
          cnt_d  = '0;
          cnt_we = 1'b1;
        end
      end
      PH_RAMP: begin
        cnt_we = 1'b1;
        if (!start_ok) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else if (cnt_q == LAST) begin
          ph_d  = PH_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_RUN: begin
        if (!en_s) ph_d = PH_IDLE;
      end
      default: begin
        ph_d   = PH_IDLE;
        cnt_d  = '0;
        cnt_we = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign phase = ph_q;
endmodule

// File: rtl/sup_prot.sv
module sup_prot
  import sup_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  input  logic   en_s,
  input  logic   ov1_s,
  input  logic   ov2_s,
  input  logic   uva_s,
  input  logic   uvb_s,
  input  logic   swok_s,
  output logic   ramp_en,
  output logic   clamp_release,
  output logic   hs_en,
  output logic   ls_en,
  output logic   crowbar,
  output logic   ldo_a_gate,
  output logic   ldo_b_gate,
  output logic   pg_pulldown
);
  logic active, running;
  logic ov1_q, ov2_q, uva_q, uvb_q;
  logic ov1_d, ov2_d, uva_d, uvb_d;

  assign active  = (phase == PH_RAMP) || (phase == PH_RUN);
  assign running = (phase == PH_RUN);

  always_comb begin
    if (!en_s) begin
      ov1_d = 1'b0;
      ov2_d = 1'b0;
      uva_d = 1'b0;
      uvb_d = 1'b0;
    end else begin
      ov1_d = ov1_q | (active  & ov1_s);
      ov2_d = ov2_q | (active  & ov2_s);
      uva_d = uva_q | (running & uva_s);
      uvb_d = uvb_q | (running & uvb_s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov1_q <= 1'b0;
      ov2_q <= 1'b0;
      uva_q <= 1'b0;
      uvb_q <= 1'b0;
    end else begin
      ov1_q <= ov1_d;
      ov2_q <= ov2_d;
      uva_q <= uva_d;
      uvb_q <= uvb_d;
    end
  end

  assign ramp_en       = (phase == PH_RAMP);
  assign clamp_release = running;
  assign ls_en         = active;
  assign hs_en         = active & ~ov1_q & ~ov2_q;
  assign crowbar       = ov2_q;
  assign ldo_a_gate    = active & ~uva_q;
  assign ldo_b_gate    = active & ~uvb_q;
  assign pg_pulldown   = ~running | ~swok_s | uva_q | uvb_q | ov1_q | ov2_q;
endmodule

// File: rtl/buck_seq_supervisor.sv
module buck_seq_supervisor
  import sup_pkg::*;
#(
  parameter int SS_CYCLES   = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  input  logic start_lvl_ok,
  input  logic enable,
  input  logic vid_ok,
  input  logic ovp_lvl1,
  input  logic ovp_lvl2,
  input  logic ldo_a_low,
  input  logic ldo_b_low,
  input  logic sw_pg_ok,
  output logic ramp_en,
  output logic clamp_release,
  output logic hs_en,
  output logic ls_en,
  output logic crowbar,
  output logic ldo_a_gate,
  output logic ldo_b_gate,
  output logic pg_pulldown
);
  logic               rst_q_n;
  logic [N_FLAGS-1:0] flags_raw, flags_s;
  logic               en_s, start_ok;
  phase_t             phase;

  always_comb begin
    flags_raw           = '0;
    flags_raw[IX_EN]    = enable;
    flags_raw[IX_VID]   = vid_ok;
    flags_raw[IX_VST]   = start_lvl_ok;
    flags_raw[IX_OV1]   = ovp_lvl1;
    flags_raw[IX_OV2]   = ovp_lvl2;
    flags_raw[IX_UVA]   = ldo_a_low;
    flags_raw[IX_UVB]   = ldo_b_low;
    flags_raw[IX_SWOK]  = sw_pg_ok;
  end

  sup_reset_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .por_ok  (por_ok),
    .rst_q_n (rst_q_n)
  );

  sup_flag_sync #(.W(N_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     (flags_raw),
    .q     (flags_s)
  );

  assign en_s     = flags_s[IX_EN];
  assign start_ok = flags_s[IX_EN] & flags_s[IX_VID] & flags_s[IX_VST];

  sup_ss_timer #(.SS_CYCLES(SS_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start_ok (start_ok),
    .en_s     (en_s),
    .phase    (phase)
  );

  sup_prot u_prot (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .phase         (phase),
    .en_s          (en_s),
    .ov1_s         (flags_s[IX_OV1]),
    .ov2_s         (flags_s[IX_OV2]),
    .uva_s         (flags_s[IX_UVA]),
    .uvb_s         (flags_s[IX_UVB]),
    .swok_s        (flags_s[IX_SWOK]),
    .ramp_en       (ramp_en),
    .clamp_release (clamp_release),
    .hs_en         (hs_en),
    .ls_en         (ls_en),
    .crowbar       (crowbar),
    .ldo_a_gate    (ldo_a_gate),
    .ldo_b_gate    (ldo_b_gate),
    .pg_pulldown   (pg_pulldown)
  );
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic clk,
  input logic rst_n,
  input logic por_ok,
  input logic rst_q_n,
  input logic start_ok,
  input logic en_s,
  input logic ramp_en,
  input logic clamp_release,
  input logic hs_en,
  input logic ls_en,
  input logic crowbar,
  input logic ldo_a_gate,
  input logic ldo_b_gate,
  input logic pg_pulldown
);
  // R1: outputs idle whenever a reset source is active
  always @(negedge clk) begin
    if (!rst_n || !por_ok) begin
      a_r1_off_in_reset: assert (!hs_en && !ls_en && !ramp_en && !clamp_release &&
                                 !crowbar && !ldo_a_gate && !ldo_b_gate && pg_pulldown);
    end
  end

  a_r2_ramp_needs_start: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(ramp_en) |-> $past(start_ok));

  a_r3_ramp_clamp_exclusive: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(ramp_en && clamp_release));

  a_r5_pg_low_in_ramp: assert property (@(posedge clk) disable iff (!rst_q_n)
    ramp_en |-> pg_pulldown);

  a_r9_crowbar_blocks_hs: assert property (@(posedge clk) disable iff (!rst_q_n)
    crowbar |-> !hs_en);

  a_r8_hs_implies_ls: assert property (@(posedge clk) disable iff (!rst_q_n)
    hs_en |-> ls_en);

  a_r10_crowbar_sticky: assert property (@(posedge clk) disable iff (!rst_q_n)
    (crowbar && en_s) |=> crowbar);

  a_r6_run_ends_on_enable: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clamp_release && en_s) |=> clamp_release);
endmodule

bind buck_seq_supervisor sup_checker u_chk (.*);

// File: tb/buck_seq_supervisor_tb.sv
module buck_seq_supervisor_tb;
  logic clk = 1'b0;
  logic rst_n, por_ok, start_lvl_ok, enable, vid_ok;
  logic ovp_lvl1, ovp_lvl2, ldo_a_low, ldo_b_low, sw_pg_ok;
  logic ramp_en, clamp_release, hs_en, ls_en, crowbar;
  logic ldo_a_gate, ldo_b_gate, pg_pulldown;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  buck_seq_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .start_lvl_ok(start_lvl_ok),
    .enable(enable), .vid_ok(vid_ok), .ovp_lvl1(ovp_lvl1), .ovp_lvl2(ovp_lvl2),
    .ldo_a_low(ldo_a_low), .ldo_b_low(ldo_b_low), .sw_pg_ok(sw_pg_ok),
    .ramp_en(ramp_en), .clamp_release(clamp_release), .hs_en(hs_en), .ls_en(ls_en),
    .crowbar(crowbar), .ldo_a_gate(ldo_a_gate), .ldo_b_gate(ldo_b_gate),
    .pg_pulldown(pg_pulldown)
  );

  // ---------------- reference model ----------------
  localparam int RAMP_LEN = 4096;
  bit [7:0] pipe[$];
  int  m_phase;   // 0 idle, 1 ramp, 2 run
  int  m_count;
  int  m_rel;     // edges since reset release
  bit  m_ov1, m_ov2, m_uva, m_uvb;

  function automatic bit [7:0] in_vec();
    return {sw_pg_ok, ldo_b_low, ldo_a_low, ovp_lvl2, ovp_lvl1, start_lvl_ok, vid_ok, enable};
  endfunction

  task automatic model_clear();
    pipe.delete(); pipe.push_back(8'h0); pipe.push_back(8'h0);
    m_phase = 0; m_count = 0; m_rel = 0;
    m_ov1 = 0; m_ov2 = 0; m_uva = 0; m_uvb = 0;
  endtask

  always @(posedge clk or negedge rst_n or negedge por_ok) begin
    if (!rst_n || !por_ok) begin
      model_clear();
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit [7:0] v;
      bit st;
      int nph;
      v  = pipe[0];
      st = v[0] && v[1] && v[2];
      nph = m_phase;
      if (!v[0]) begin
        m_ov1 = 0; m_ov2 = 0; m_uva = 0; m_uvb = 0;
      end else begin
        if (m_phase != 0 && v[3]) m_ov1 = 1;
        if (m_phase != 0 && v[4]) m_ov2 = 1;
        if (m_phase == 2 && v[5]) m_uva = 1;
        if (m_phase == 2 && v[6]) m_uvb = 1;
      end
      if (m_phase == 0) begin
        if (st) begin nph = 1; m_count = 0; end
      end else if (m_phase == 1) begin
        if (!st) begin nph = 0; m_count = 0; end
        else if (m_count == RAMP_LEN - 1) begin nph = 2; m_count = 0; end
        else m_count++;
      end else begin
        if (!v[0]) nph = 0;
      end
      m_phase = nph;
      void'(pipe.pop_front());
      pipe.push_back(in_vec());
    end
  end

  initial model_clear();

  task automatic chk(string req, string nm, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
    end
  endtask

  // compare every output each cycle, away from the active edge
  always @(negedge clk) begin
    if (done) ;
    else begin
      bit act, run, swok;
      act  = (m_phase != 0);
      run  = (m_phase == 2);
      swok = pipe[0][7];
      chk("R2", "ramp_en",       ramp_en,       m_phase == 1);
      chk("R3", "clamp_release", clamp_release, run);
      chk("R6", "ls_en",         ls_en,         act);
      chk("R8", "hs_en",         hs_en,         act && !m_ov1 && !m_ov2);
      chk("R9", "crowbar",       crowbar,       m_ov2);
      chk("R7", "ldo_a_gate",    ldo_a_gate,    act && !m_uva);
      chk("R7", "ldo_b_gate",    ldo_b_gate,    act && !m_uvb);
      chk("R5", "pg_pulldown",   pg_pulldown,
          !run || !swok || m_uva || m_uvb || m_ov1 || m_ov2);
    end
  end

  // independent ramp length measurement for R3/R4
  int ramp_run = 0;
  int last_ramp_len = 0;
  always @(negedge clk) begin
    if (ramp_en) ramp_run++;
    else if (ramp_run != 0) begin last_ramp_len = ramp_run; ramp_run = 0; end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    rst_n = 0; por_ok = 0; start_lvl_ok = 0; enable = 0; vid_ok = 0;
    ovp_lvl1 = 0; ovp_lvl2 = 0; ldo_a_low = 0; ldo_b_low = 0; sw_pg_ok = 0;
    step(3);
    // R1: reset state
    chk("R1", "pg_pulldown in reset", pg_pulldown, 1'b1);
    chk("R1", "hs_en in reset", hs_en, 1'b0);
    rst_n = 1;
    enable = 1; vid_ok = 1; start_lvl_ok = 1;
    step(10);
    // R1: por_ok low still holds everything
    chk("R1", "ramp_en with supply below reset", ramp_en, 1'b0);
    chk("R1", "ls_en with supply below reset", ls_en, 1'b0);
    por_ok = 1;
    enable = 0;
    step(5);
    // R2: two of three conditions are not enough
    enable = 1; start_lvl_ok = 0;
    step(20);
    chk("R2", "no ramp without start level", ramp_en, 1'b0);
    start_lvl_ok = 1;
    step(2);
    chk("R2", "ramp not yet after two edges", ramp_en, 1'b0);
    step(1);
    chk("R2", "ramp after third edge", ramp_en, 1'b1);
    // R4: abort mid-ramp by VID loss
    step(1000);
    vid_ok = 0;
    step(5);
    chk("R4", "ramp aborted", ramp_en, 1'b0);
    vid_ok = 1;
    step(3);
    chk("R4", "ramp restarted", ramp_en, 1'b1);
    sw_pg_ok = 1;
    step(RAMP_LEN + 5);
    chk("R3", "clamp released", clamp_release, 1'b1);
    n_checks++;
    if (last_ramp_len != RAMP_LEN) begin
      n_fail++;
      $display("FAIL R3 ramp length actual=%0d expected=%0d", last_ramp_len, RAMP_LEN);
    end
    chk("R5", "pg released in run", pg_pulldown, 1'b0);
    // R6: loss of VID in run does not end it
    vid_ok = 0; start_lvl_ok = 0;
    step(6);
    chk("R6", "run survives vid loss", clamp_release, 1'b1);
    vid_ok = 1; start_lvl_ok = 1;
    // R5: monitor follows
    sw_pg_ok = 0;
    step(4);
    chk("R5", "pg low on window loss", pg_pulldown, 1'b1);
    sw_pg_ok = 1;
    step(4);
    // R7: undervoltage latch on A
    ldo_a_low = 1;
    step(4);
    ldo_a_low = 0;
    step(6);
    chk("R7", "ldo_a gate latched off", ldo_a_gate, 1'b0);
    chk("R7", "ldo_b gate unaffected", ldo_b_gate, 1'b1);
    chk("R7", "pg low after uv", pg_pulldown, 1'b1);
    // R8: first tier overvoltage
    ovp_lvl1 = 1;
    step(4);
    ovp_lvl1 = 0;
    step(4);
    chk("R8", "hs off on ovp1", hs_en, 1'b0);
    chk("R8", "ls on on ovp1", ls_en, 1'b1);
    chk("R9", "no crowbar on ovp1", crowbar, 1'b0);
    // R9: second tier
    ovp_lvl2 = 1;
    step(4);
    ovp_lvl2 = 0;
    step(20);
    chk("R9", "crowbar fired", crowbar, 1'b1);
    chk("R10", "crowbar latched", crowbar, 1'b1);
    // R6 / R10: enable low clears all
    enable = 0;
    step(2);
    chk("R6", "still running two edges after enable drop", ls_en, 1'b1);
    step(1);
    chk("R6", "ls off after enable drop", ls_en, 1'b0);
    chk("R6", "ldo_b off after enable drop", ldo_b_gate, 1'b0);
    chk("R10", "crowbar cleared", crowbar, 1'b0);
    step(5);
    enable = 1;
    step(3);
    chk("R10", "hs back during new ramp", hs_en, 1'b1);
    chk("R10", "ldo_a back during new ramp", ldo_a_gate, 1'b1);
    step(RAMP_LEN + 5);
    chk("R10", "run again after new ramp", clamp_release, 1'b1);
    n_checks++;
    if (last_ramp_len != RAMP_LEN) begin
      n_fail++;
      $display("FAIL R3 second ramp length actual=%0d expected=%0d", last_ramp_len, RAMP_LEN);
    end
    // R1: supply drop while running
    por_ok = 0;
    step(1);
    chk("R1", "hs off on supply drop", hs_en, 1'b0);
    chk("R1", "pg low on supply drop", pg_pulldown, 1'b1);
    por_ok = 1;
    step(10);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule